// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Control with Fast Fault Shutdown

This block is the digital control core of a three-leg inverter. Each leg takes an active-high high-side command and an active-high low-side command. It produces a high-side and a low-side gate enable. It inserts a programmable dead time between one switch turning off and any switch of the same leg turning on. It treats a request for both switches at once as a request to turn the leg off, not as a priority.

All three legs share one active-low shutdown line. The block reads the line as a clean synchronous bit, `sd_n`. The block also drives a pull-down enable for that line, which is open-drain on the board side.

A shared overcurrent flag has its own fast path. It blanks every gate output in the same cycle and does not wait for the external RC network on the shutdown line. The flag also turns on the pull-down. The pull-down stays on until the line is sampled low. The legs then resume only after the line reads high again. Per-leg supply and bootstrap undervoltage flags, with hysteresis applied upstream, arrive as plain bits and lock out the switches they affect.

The interface is plain control pins with no stream or handshake.

Top module: `halfbridge_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, every gate output and `od_en` are low. No gate output rises until DEAD_CYC+1 clock edges have passed after reset release.
- R2: A low sample of `sd_n` drives both gate outputs of every leg low at the next clock edge, whatever the commands are. A shutdown read on the line alone never raises `od_en`.
- R3: When a leg's high-side and low-side commands are both 1, both of its gate outputs go low at the next edge. The two gate outputs of a leg are never high together.
- R4: With the shutdown line high and no lockout, a leg with only its high-side command set drives only `hvg` high. A leg with only its low-side command set drives only `lvg` high. A leg with both commands 0 drives both outputs low.
- R5: Once both outputs of a leg are low, neither may rise until they have stayed low for at least DEAD_CYC clock cycles. A command swap turns the old side off at the first edge and the new side on at edge DEAD_CYC+2.
- R6: While `oc_flag` is 1, every gate output is 0 in the same cycle, with no clock edge needed.
- R7: A 1 on `oc_flag` sets `od_en` at the next edge. `od_en` then stays 1 for as long as `sd_n` reads 1, and drops at the first edge on which `sd_n` is sampled 0.
- R8: After `od_en` drops, the gate outputs stay low until `sd_n` has been sampled 1 again. The first turn-on after that still obeys R5.
- R9: `uv_vcc[i]`=1 forces both outputs of leg i low at the next edge. `uv_boot[i]`=1 forces only `hvg[i]` low and leaves `lvg[i]` free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hin | input | NPH | High-side command per leg, active high |
| lin | input | NPH | Low-side command per leg, active high |
| sd_n | input | 1 | Sampled shared shutdown line, 0 = below logic-low threshold |
| oc_flag | input | 1 | Shared overcurrent comparator result, 1 = fault |
| uv_vcc | input | NPH | Supply undervoltage per leg, 1 = locked out |
| uv_boot | input | NPH | Bootstrap undervoltage per leg, 1 = high side locked out |
| hvg | output | NPH | High-side gate enable per leg |
| lvg | output | NPH | Low-side gate enable per leg |
| od_en | output | 1 | Pull-down enable for the shared shutdown line |

## Verification
The checks assume that every input is already synchronous to `clk` and glitch-free within a cycle. In particular, they assume that `oc_flag` changes only between edges. Otherwise the same-cycle blanking could not be related to sampled values.

The stimulus changes inputs one nanosecond after a rising edge and holds them for whole cycles. It models the board's RC delay on the shutdown line by keeping `sd_n` high for several cycles after a fault, before it lets the line fall.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    FLT_IDLE = 2'd0,
    FLT_HOLD = 2'd1,
    FLT_WAIT = 2'd2
  } flt_state_t;
endpackage

// File: rtl/hb_fault_ctl.sv
module hb_fault_ctl
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic sd_n,
  output logic od_en,
  output logic fault_idle
);
  flt_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FLT_IDLE: if (oc_flag) state_d = FLT_HOLD;
      FLT_HOLD: if (!sd_n)   state_d = FLT_WAIT;
      FLT_WAIT: begin
        if (oc_flag)   state_d = FLT_HOLD;
        else if (sd_n) state_d = FLT_IDLE;
      end
      default: state_d = FLT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FLT_IDLE;
    else        state_q <= state_d;
  end

  assign od_en      = (state_q == FLT_HOLD);
  assign fault_idle = (state_q == FLT_IDLE);
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DEAD_CYC = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic allow,
  input  logic uv_vcc,
  input  logic uv_boot,
  input  logic fast_kill,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEAD_CYC);

  logic          want_hi, want_lo;
  logic          hi_q, lo_q;
  logic [CW-1:0] gap_q;
  logic          gap_done;

  assign want_hi  = cmd_hi & ~cmd_lo & allow & ~uv_vcc & ~uv_boot;
  assign want_lo  = cmd_lo & ~cmd_hi & allow & ~uv_vcc;
  assign gap_done = (gap_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      if (hi_q && !want_hi) hi_q <= 1'b0;
      if (lo_q && !want_lo) lo_q <= 1'b0;
      if (!hi_q && !lo_q && gap_done) begin
        hi_q <= want_hi;
        lo_q <= want_lo;
      end
      if (hi_q || lo_q)  gap_q <= '0;
      else if (!gap_done) gap_q <= gap_q + 1'b1;
    end
  end

  assign gate_hi = hi_q & ~fast_kill;
  assign gate_lo = lo_q & ~fast_kill;
endmodule

// File: rtl/halfbridge_ctl.sv
module halfbridge_ctl #(
  parameter int NPH      = 3,
  parameter int DEAD_CYC = 45
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hin,
  input  logic [NPH-1:0] lin,
  input  logic           sd_n,
  input  logic           oc_flag,
  input  logic [NPH-1:0] uv_vcc,
  input  logic [NPH-1:0] uv_boot,
  output logic [NPH-1:0] hvg,
  output logic [NPH-1:0] lvg,
  output logic           od_en
);
  logic fault_idle;
  logic leg_allow;

  hb_fault_ctl u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_flag    (oc_flag),
    .sd_n       (sd_n),
    .od_en      (od_en),
    .fault_idle (fault_idle)
  );

  assign leg_allow = sd_n & fault_idle & ~oc_flag;

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_hi    (hin[g]),
      .cmd_lo    (lin[g]),
      .allow     (leg_allow),
      .uv_vcc    (uv_vcc[g]),
      .uv_boot   (uv_boot[g]),
      .fast_kill (oc_flag),
      .gate_hi   (hvg[g]),
      .gate_lo   (lvg[g])
    );
  end
endmodule

// File: rtl/hb_ctl_chk.sv
module hb_ctl_chk #(
  parameter int NPH      = 3,
  parameter int DEAD_CYC = 45
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] hin,
  input logic [NPH-1:0] lin,
  input logic           sd_n,
  input logic           oc_flag,
  input logic [NPH-1:0] uv_vcc,
  input logic [NPH-1:0] uv_boot,
  input logic [NPH-1:0] hvg,
  input logic [NPH-1:0] lvg,
  input logic           od_en
);
  localparam int CW = $clog2(DEAD_CYC + 1);

  // R6
  oc_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |-> (hvg == '0 && lvg == '0));

  // R7
  od_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> od_en);

  // R7
  od_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_en && sd_n) |=> od_en);

  // R2
  sd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> (hvg == '0 && lvg == '0));

  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od_en) |-> (hvg == '0 && lvg == '0));

  for (genvar g = 0; g < NPH; g++) begin : g_chk
    logic [CW-1:0] off_cnt;
    logic          on_any;
    assign on_any = hvg[g] | lvg[g];

    always_ff @(posedge clk) begin
      if (!rst_n)                         off_cnt <= '0;
      else if (on_any)                    off_cnt <= '0;
      else if (off_cnt != CW'(DEAD_CYC))  off_cnt <= off_cnt + 1'b1;
    end

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hvg[g] && lvg[g]));

    // R3
    both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hin[g] && lin[g]) |=> (!hvg[g] && !lvg[g]));

    // R5
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_any) |-> (off_cnt == CW'(DEAD_CYC)));

    // R9
    uv_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_vcc[g] |=> (!hvg[g] && !lvg[g]));

    // R9
    uv_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_boot[g] |=> !hvg[g]);
  end
endmodule

bind halfbridge_ctl hb_ctl_chk #(.NPH(NPH), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hin     (hin),
  .lin     (lin),
  .sd_n    (sd_n),
  .oc_flag (oc_flag),
  .uv_vcc  (uv_vcc),
  .uv_boot (uv_boot),
  .hvg     (hvg),
  .lvg     (lvg),
  .od_en   (od_en)
);

// File: tb/halfbridge_ctl_tb.sv
module halfbridge_ctl_tb;
  localparam int NPH  = 3;
  localparam int DEAD = 45;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NPH-1:0] hin, lin, uv_vcc, uv_boot;
  logic           sd_n, oc_flag;
  logic [NPH-1:0] hvg, lvg;
  logic           od_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  halfbridge_ctl #(.NPH(NPH), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .hin(hin), .lin(lin), .sd_n(sd_n),
    .oc_flag(oc_flag), .uv_vcc(uv_vcc), .uv_boot(uv_boot),
    .hvg(hvg), .lvg(lvg), .od_en(od_en)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_gates(input string tag,
                           input logic [NPH-1:0] eh, input logic [NPH-1:0] el);
    chk(hvg == eh && lvg == el, tag, {hvg, lvg}, {eh, el});
  endtask

  task automatic go_idle();
    hin = '0; lin = '0; sd_n = 1'b1; oc_flag = 1'b0; uv_vcc = '0; uv_boot = '0;
    step(DEAD + 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    hin = '0; lin = '0; sd_n = 1'b1; oc_flag = 1'b0; uv_vcc = '0; uv_boot = '0;
    step(3);
    chk_gates("R1 in reset", '0, '0);
    chk(od_en == 1'b0, "R1 od_en in reset", od_en, 0);
    rst_n = 1'b1;
    hin = '1;
    step(DEAD);
    chk_gates("R1 no turn-on before dead time", '0, '0);
    step(1);
    chk_gates("R1 first turn-on after dead time", '1, '0);
  endtask

  task automatic t_single();
    go_idle();
    hin = 3'b001; lin = 3'b010;
    step(1);
    chk_gates("R4 single commands", 3'b001, 3'b010);
    hin = 3'b011; lin = 3'b011;
    step(1);
    chk_gates("R3 both commands turn leg off", '0, '0);
    step(DEAD + 3);
    chk_gates("R3 both commands stay off", '0, '0);
    hin = '0; lin = '0;
    step(DEAD + 3);
    chk_gates("R4 no command off", '0, '0);
  endtask

  task automatic t_deadtime();
    go_idle();
    hin = 3'b001;
    step(1);
    chk_gates("R5 high side on", 3'b001, '0);
    hin = '0; lin = 3'b001;
    step(1);
    chk_gates("R5 old side off at once", '0, '0);
    step(DEAD);
    chk_gates("R5 new side held during gap", '0, '0);
    step(1);
    chk_gates("R5 new side on after gap", '0, 3'b001);
  endtask

  task automatic t_shutdown();
    go_idle();
    hin = '1;
    step(1);
    chk_gates("R4 all high sides on", '1, '0);
    sd_n = 1'b0;
    step(1);
    chk_gates("R2 shutdown blanks outputs", '0, '0);
    chk(od_en == 1'b0, "R2 shutdown alone leaves od_en off", od_en, 0);
    sd_n = 1'b1;
    step(DEAD);
    chk_gates("R5 dead time after shutdown", '0, '0);
    step(1);
    chk_gates("R2 resume after shutdown", '1, '0);
  endtask

  task automatic t_overcurrent();
    go_idle();
    hin = 3'b010; lin = 3'b001;
    step(1);
    chk_gates("R4 mixed legs on", 3'b010, 3'b001);
    oc_flag = 1'b1;
    #1;
    chk_gates("R6 same-cycle blanking", '0, '0);
    step(1);
    chk(od_en == 1'b1, "R7 od_en set", od_en, 1);
    oc_flag = 1'b0;
    step(4);
    chk(od_en == 1'b1, "R7 od_en held while line high", od_en, 1);
    chk_gates("R7 outputs off while held", '0, '0);
    sd_n = 1'b0;
    step(1);
    chk(od_en == 1'b0, "R7 od_en released on low line", od_en, 0);
    step(DEAD + 2);
    chk_gates("R8 off while line low", '0, '0);
    sd_n = 1'b1;
    step(1);
    chk_gates("R8 off on first high sample", '0, '0);
    step(1);
    chk_gates("R8 resume after line high", 3'b010, 3'b001);
  endtask

  task automatic t_uv();
    go_idle();
    hin = 3'b001; lin = 3'b010;
    step(1);
    chk_gates("R4 uv setup", 3'b001, 3'b010);
    uv_boot = 3'b011;
    step(1);
    chk_gates("R9 bootstrap lockout high side only", '0, 3'b010);
    uv_boot = '0; uv_vcc = 3'b010;
    step(1);
    chk(lvg[1] == 1'b0 && hvg[1] == 1'b0, "R9 supply lockout both sides",
        {hvg[1], lvg[1]}, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_deadtime();
    t_shutdown();
    t_overcurrent();
    t_uv();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule